// File: doc/BRIEF.md
# Serially Loaded Pulse-Template Sample Memory

This block keeps the digital template of one transmitted line pulse as a list of signed amplitude samples, one per phase of the symbol. A host fills the list and reads it back over a four-wire synchronous serial port made up of a serial clock, data in, data out and an active-low select. The block samples the serial pins with its own system clock, so the serial clock has to run well below the system clock.

The first byte of every transfer is a command byte, and its bit 0 sets the direction. For a write, the sample bytes that follow fill the phases in order, starting at phase 0. For a read, an address byte follows and the stored sample then shifts out on the data-out pin.

A symbol strobe starts playback. The block takes a copy of the written samples at that moment and steps through the phases, one per phase tick, on a 7-bit amplitude bus that feeds a line DAC. A host can reload the template while a symbol is playing without corrupting that symbol.

Top module: `pulse_wave_ram`

## Requirements
- R1: After reset, `amp_out` is 0, `playing` is 0, `sdo` is 0, and every phase entry reads back as 0x00.
- R2: A transfer whose first byte has bit 0 = 0 is a write. Each later byte goes to phases 0, 1, 2 and so on in turn. Only bits 6:0 are kept as the signed sample, and bit 7 is ignored. The largest positive sample is 0x3F and the most negative is 0x40.
- R3: Write bytes past the last phase (from the 17th sample byte on) are discarded. Phase 0 does not get overwritten.
- R4: A transfer whose first byte has bit 0 = 1 is a read, and its second byte is the entry address. Every later byte shifts out on `sdo`, MSB first, as {0, sample} of that same entry. `sdo` changes after a falling serial-clock edge and is valid at the next rising edge.
- R5: A read address of 16 or more returns 0x00.
- R6: Raising `cs_n` ends the transfer, drops any partial byte and forces `sdo` to 0. The next transfer starts again with a command byte.
- R7: A `sym_strobe` arms playback. The next 16 cycles with `phase_tick` high put phases 0 to 15 in order on `amp_out`. Each value is registered on the clock edge that samples the tick.
- R8: The tick after phase 15 drives `amp_out` to 0 and clears `playing`. Ticks that arrive while idle leave `amp_out` at 0.
- R9: Playback uses the samples as they were at the strobe. Writes made during a symbol take effect only from the next strobe.
- R10: A strobe during playback restarts at phase 0 with a fresh copy of the samples. If a strobe and a tick come in the same cycle, the tick is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data in, sampled on rising sclk |
| cs_n | input | 1 | Active-low transfer select |
| sdo | output | 1 | Serial read data, updated after falling sclk |
| sym_strobe | input | 1 | One-cycle start of a symbol |
| phase_tick | input | 1 | One-cycle phase advance |
| amp_out | output | 7 | Signed two's-complement phase amplitude |
| playing | output | 1 | High while a symbol is being stepped |

## Verification
The template is loaded with directed extreme codes and with random bytes whose top bit is set. This shows that bit 7 is dropped and that the sign-carrying bits are kept, for both 0x3F and 0x40. Readback covers random in-range and out-of-range addresses, repeated data bytes and an aborted partial write. These cases tell correct address decoding apart from aliasing, and correct abort handling from a stray commit. Playback is tried with a full run followed by idle ticks, with a mid-symbol reload and with a mid-symbol restart. These separate snapshot-at-strobe behaviour from live reads of the written samples.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int unsigned SLOT_W   = 8;
  localparam int unsigned SAMPLE_W = SLOT_W - 1;

  typedef enum logic [1:0] {
    SP_CMD   = 2'd0,
    SP_WDATA = 2'd1,
    SP_RADDR = 2'd2,
    SP_RDATA = 2'd3
  } sp_state_t;

  // Drop the unused top bit of a received slot.
  function automatic logic [SAMPLE_W-1:0] slot_to_sample(input logic [SLOT_W-1:0] slot);
    return slot[SAMPLE_W-1:0];
  endfunction

  // Readback image of a stored sample: top bit always zero.
  function automatic logic [SLOT_W-1:0] sample_to_slot(input logic [SAMPLE_W-1:0] s);
    return {1'b0, s};
  endfunction
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign level = pipe_q[STAGES-1];
endmodule

// File: rtl/pwr_serial_port.sv
module pwr_serial_port
  import pwr_pkg::*;
#(
  parameter int unsigned PHASES = 16,
  parameter int unsigned ADDR_W = $clog2(PHASES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_lvl,
  input  logic                sdi_lvl,
  input  logic                cs_act,
  input  logic [SLOT_W-1:0]   rd_slot,
  output logic [SLOT_W-1:0]   rd_addr,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [SAMPLE_W-1:0] wr_sample,
  output logic                sdo
);
  localparam logic [ADDR_W:0] PTR_END = (ADDR_W+1)'(PHASES);

  sp_state_t         state_q;
  logic              sclk_prev_q;
  logic [SLOT_W-1:0] rx_q;
  logic [2:0]        bit_q;
  logic [ADDR_W:0]   wptr_q;
  logic [SLOT_W-1:0] tx_q;
  logic [SLOT_W-1:0] raddr_q;

  // Named internal events
  logic              sclk_rise, sclk_fall, byte_done;
  logic [SLOT_W-1:0] rx_byte;

  assign sclk_rise = cs_act &  sclk_lvl & ~sclk_prev_q;
  assign sclk_fall = cs_act & ~sclk_lvl &  sclk_prev_q;
  assign rx_byte   = {rx_q[SLOT_W-2:0], sdi_lvl};
  assign byte_done = sclk_rise & (bit_q == 3'd7);

  assign wr_en     = byte_done & (state_q == SP_WDATA) & (wptr_q < PTR_END);
  assign wr_addr   = wptr_q[ADDR_W-1:0];
  assign wr_sample = slot_to_sample(rx_byte);
  assign rd_addr   = (state_q == SP_RADDR) ? rx_byte : raddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SP_CMD;
      sclk_prev_q <= 1'b0;
      rx_q        <= '0;
      bit_q       <= '0;
      wptr_q      <= '0;
      tx_q        <= '0;
      raddr_q     <= '0;
      sdo         <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_lvl;
      if (!cs_act) begin
        state_q <= SP_CMD;
        rx_q    <= '0;
        bit_q   <= '0;
        tx_q    <= '0;
        sdo     <= 1'b0;
      end else begin
        if (sclk_rise) begin
          rx_q  <= rx_byte;
          bit_q <= bit_q + 3'd1;
        end
        if (byte_done) begin
          unique case (state_q)
            SP_CMD: begin
              state_q <= rx_byte[0] ? SP_RADDR : SP_WDATA;
              wptr_q  <= '0;
            end
            SP_WDATA: begin
              if (wptr_q < PTR_END) wptr_q <= wptr_q + 1'b1;
            end
            SP_RADDR: begin
              raddr_q <= rx_byte;
              tx_q    <= rd_slot;
              state_q <= SP_RDATA;
            end
            SP_RDATA: tx_q <= rd_slot;
            default:  state_q <= SP_CMD;
          endcase
        end
        if (sclk_fall && state_q == SP_RDATA) begin
          sdo  <= tx_q[SLOT_W-1];
          tx_q <= {tx_q[SLOT_W-2:0], 1'b0};
        end
      end
    end
  end

  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo); // R6
  AST_DESELECT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (state_q == SP_CMD && bit_q == 3'd0)); // R6
  AST_WPTR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_q <= PTR_END); // R3
  AST_SDO_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SP_RDATA) |=> (sdo == $past(sdo) || !sdo)); // R4
endmodule

// File: rtl/pwr_sample_bank.sv
module pwr_sample_bank
  import pwr_pkg::*;
#(
  parameter int unsigned PHASES = 16,
  parameter int unsigned ADDR_W = $clog2(PHASES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [SAMPLE_W-1:0] wr_sample,
  input  logic [SLOT_W-1:0]   rd_addr,
  output logic [SLOT_W-1:0]   rd_slot,
  input  logic                snap,
  input  logic [ADDR_W-1:0]   play_idx,
  output logic [SAMPLE_W-1:0] play_sample
);
  logic [SAMPLE_W-1:0]        stage_q [PHASES];
  logic [SAMPLE_W-1:0]        live_q  [PHASES];
  logic [PHASES*SAMPLE_W-1:0] stage_flat, live_flat;

  for (genvar g = 0; g < PHASES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g] <= '0;
        live_q[g]  <= '0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(g)) stage_q[g] <= wr_sample;
        if (snap)                           live_q[g]  <= stage_q[g];
      end
    end
    assign stage_flat[g*SAMPLE_W +: SAMPLE_W] = stage_q[g];
    assign live_flat[g*SAMPLE_W +: SAMPLE_W]  = live_q[g];
  end

  logic rd_in_range;
  assign rd_in_range = (32'(rd_addr) < PHASES);
  assign rd_slot     = rd_in_range ? sample_to_slot(stage_q[rd_addr[ADDR_W-1:0]]) : '0;
  assign play_sample = live_q[play_idx];

  AST_LIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(live_flat)); // R9
  AST_STAGE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(stage_flat)); // R3
endmodule

// File: rtl/pwr_phase_seq.sv
module pwr_phase_seq
  import pwr_pkg::*;
#(
  parameter int unsigned PHASES = 16,
  parameter int unsigned ADDR_W = $clog2(PHASES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sym_strobe,
  input  logic                phase_tick,
  input  logic [SAMPLE_W-1:0] play_sample,
  output logic [ADDR_W-1:0]   play_idx,
  output logic                snap,
  output logic [SAMPLE_W-1:0] amp_out,
  output logic                playing
);
  localparam logic [ADDR_W:0] IDX_END = (ADDR_W+1)'(PHASES);

  logic [ADDR_W:0] idx_q;
  logic            step, finish;

  assign snap     = sym_strobe;
  assign step     = phase_tick & playing & ~sym_strobe;
  assign finish   = step & (idx_q == IDX_END);
  assign play_idx = idx_q[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      amp_out <= '0;
      playing <= 1'b0;
    end else if (sym_strobe) begin
      idx_q   <= '0;
      playing <= 1'b1;
    end else if (finish) begin
      idx_q   <= '0;
      amp_out <= '0;
      playing <= 1'b0;
    end else if (step) begin
      idx_q   <= idx_q + 1'b1;
      amp_out <= play_sample;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !playing |-> (amp_out == '0)); // R8
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_END); // R7
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !finish) |=> (idx_q == $past(idx_q) + 1'b1)); // R7
  AST_STROBE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sym_strobe |=> (playing && idx_q == '0)); // R10
endmodule

// File: rtl/pulse_wave_ram.sv
module pulse_wave_ram
  import pwr_pkg::*;
#(
  parameter int unsigned PHASES      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                sdi,
  input  logic                cs_n,
  output logic                sdo,
  input  logic                sym_strobe,
  input  logic                phase_tick,
  output logic [SAMPLE_W-1:0] amp_out,
  output logic                playing
);
  localparam int unsigned ADDR_W = $clog2(PHASES);

  logic sclk_lvl, sdi_lvl, cs_n_lvl;
  logic                wr_en, snap;
  logic [ADDR_W-1:0]   wr_addr, play_idx;
  logic [SAMPLE_W-1:0] wr_sample, play_sample;
  logic [SLOT_W-1:0]   rd_addr, rd_slot;

  pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .din(sclk), .level(sclk_lvl));
  pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .din(sdi), .level(sdi_lvl));
  pwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .level(cs_n_lvl));

  pwr_serial_port #(.PHASES(PHASES), .ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n), .sclk_lvl(sclk_lvl), .sdi_lvl(sdi_lvl),
    .cs_act(~cs_n_lvl), .rd_slot(rd_slot), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_sample(wr_sample), .sdo(sdo));

  pwr_sample_bank #(.PHASES(PHASES), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_sample(wr_sample), .rd_addr(rd_addr), .rd_slot(rd_slot),
    .snap(snap), .play_idx(play_idx), .play_sample(play_sample));

  pwr_phase_seq #(.PHASES(PHASES), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sym_strobe(sym_strobe), .phase_tick(phase_tick),
    .play_sample(play_sample), .play_idx(play_idx), .snap(snap),
    .amp_out(amp_out), .playing(playing));

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (amp_out == '0 && !playing && !sdo)); // R1
endmodule

// File: tb/test_pulse_wave_ram.sv
`timescale 1ns/1ps
module test_pulse_wave_ram;
  localparam int PH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1;
  logic sym_strobe = 1'b0, phase_tick = 1'b0;
  logic sdo, playing;
  logic [6:0] amp_out;

  always #2.5 clk = ~clk;

  pulse_wave_ram #(.PHASES(PH)) i_pulse_wave_ram (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n), .sdo(sdo),
    .sym_strobe(sym_strobe), .phase_tick(phase_tick),
    .amp_out(amp_out), .playing(playing));

  int checks = 0, errors = 0;
  logic [6:0] model  [PH];
  logic [6:0] live_m [PH];
  logic [7:0] wbuf   [PH+4];

  function automatic logic [7:0] exp_slot(input int a);
    if (a < PH) return {1'b0, model[a]};
    return 8'h00;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sdi = tx[i];
      wclk(8);
      rx[i] = sdo;
      sclk = 1'b1;
      wclk(8);
      sclk = 1'b0;
    end
  endtask

  task automatic host_write(input logic [7:0] cmd, input int n);
    logic [7:0] rx;
    cs_n = 1'b0; wclk(6);
    xfer(cmd, rx);
    for (int k = 0; k < n; k++) begin
      xfer(wbuf[k], rx);
      if (k < PH) model[k] = wbuf[k][6:0];
    end
    wclk(6); cs_n = 1'b1; wclk(8);
  endtask

  task automatic host_read(input string req, input logic [7:0] addr, input int reps);
    logic [7:0] rx;
    cs_n = 1'b0; wclk(6);
    xfer(8'h01 | ($urandom() & 8'hFE), rx);
    xfer(addr, rx);
    for (int r = 0; r < reps; r++) begin
      xfer($urandom(), rx);
      check(req, $sformatf("read addr %0d", addr), rx, exp_slot(addr));
    end
    wclk(6); cs_n = 1'b1; wclk(8);
  endtask

  task automatic strobe();
    sym_strobe = 1'b1; wclk(1); sym_strobe = 1'b0;
    for (int k = 0; k < PH; k++) live_m[k] = model[k];
  endtask

  task automatic tick();
    phase_tick = 1'b1; wclk(1); phase_tick = 1'b0;
  endtask

  task automatic play_run(input string req, input int from, input int to);
    for (int k = from; k <= to; k++) begin
      tick();
      check(req, $sformatf("phase %0d", k), amp_out, live_m[k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    int unsigned seed_set;
    seed_set = $urandom(32'd777);
    for (int k = 0; k < PH; k++) model[k] = '0;
    wclk(4); rst_n = 1'b1; wclk(4);

    // R1 reset state
    check("R1", "amp_out", amp_out, 0);
    check("R1", "playing", playing, 0);
    check("R1", "sdo", sdo, 0);
    host_read("R1", 8'd0, 1);
    host_read("R1", 8'd15, 1);

    // R2 directed extreme codes, top bit ignored
    wbuf[0] = 8'h3F; wbuf[1] = 8'h40; wbuf[2] = 8'hBF; wbuf[3] = 8'hC0;
    wbuf[4] = 8'h80; wbuf[5] = 8'h01; wbuf[6] = 8'h7F;
    for (int k = 7; k < PH; k++) wbuf[k] = 8'(k * 5);
    host_write(8'hA4, PH);
    host_read("R2", 8'd0, 1);
    host_read("R2", 8'd1, 1);
    host_read("R2", 8'd2, 2);
    host_read("R2", 8'd3, 1);
    host_read("R2", 8'd4, 1);
    host_read("R4", 8'd6, 3);

    // R3 extra bytes discarded, no wrap onto phase 0
    for (int k = 0; k < PH + 3; k++) wbuf[k] = 8'($urandom());
    host_write(8'h00, PH + 3);
    host_read("R3", 8'd0, 1);
    host_read("R3", 8'd15, 1);

    // R5 out-of-range addresses
    host_read("R5", 8'd16, 1);
    host_read("R5", 8'd200, 2);

    // R6 abort mid-byte: nothing committed, sdo quiet
    cs_n = 1'b0; wclk(6);
    xfer(8'h00, rx);
    for (int i = 0; i < 4; i++) begin
      sdi = 1'b1; wclk(8); sclk = 1'b1; wclk(8); sclk = 1'b0;
    end
    wclk(4); cs_n = 1'b1; wclk(8);
    check("R6", "sdo after deselect", sdo, 0);
    host_read("R6", 8'd0, 1);

    // R7 / R8 full playback then idle ticks
    strobe();
    check("R7", "playing after strobe", playing, 1);
    play_run("R7", 0, PH - 1);
    tick();
    check("R8", "amp after last phase", amp_out, 0);
    check("R8", "playing cleared", playing, 0);
    tick(); tick();
    check("R8", "idle ticks", amp_out, 0);

    // R9 reload during playback
    strobe();
    play_run("R9", 0, 4);
    for (int k = 0; k < PH; k++) wbuf[k] = 8'($urandom());
    host_write(8'h00, PH);
    play_run("R9", 5, PH - 1);
    tick();
    strobe();
    play_run("R9", 0, 3);

    // R10 restart during playback; strobe with tick same cycle
    strobe();
    play_run("R10", 0, 6);
    sym_strobe = 1'b1; phase_tick = 1'b1; wclk(1);
    sym_strobe = 1'b0; phase_tick = 1'b0;
    for (int k = 0; k < PH; k++) live_m[k] = model[k];
    check("R10", "amp held on restart", amp_out, live_m[6]);
    play_run("R10", 0, PH - 1);
    tick();

    // Random rounds
    for (int rnd = 0; rnd < 3; rnd++) begin
      int n;
      n = 1 + int'($urandom() % (PH + 2));
      for (int k = 0; k < PH + 2; k++) wbuf[k] = 8'($urandom());
      host_write(8'($urandom()) & 8'hFE, n);
      for (int q = 0; q < 4; q++) host_read("R4", 8'($urandom() % 24), 1 + int'($urandom() % 2));
      strobe();
      play_run("R7", 0, PH - 1);
      tick();
      check("R8", "end of random symbol", amp_out, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule